// File: doc/BRIEF.md
# Dual-Edge Qualified Cascadable Digit Counter

This block is a small counter that advances through either sixteen or ten states. The width of the count is derived from the state count: four bits in both variants. The count is stepped by two control inputs. Each input can act as the stepping clock while the other gates it. A rising transition on the rise-step input advances the count while the fall-step input is high. A falling transition on the fall-step input advances the count while the rise-step input is low. A level-sensitive zero input empties the counter and holds it empty.

All three control inputs are asynchronous to the block. Each passes through a two-stage synchronizer clocked by the fast system clock. Transitions are then found by comparing each synchronized level with its level one system cycle earlier. The gating condition is taken from the other input's level before that cycle. If both inputs move together in a qualifying way, the count advances exactly once.

All count bits change on the same system-clock edge. A second counter can be chained to the first in ripple fashion: tie the second counter's rise-step input low and drive its fall-step input from the most significant output bit of the first. The second counter then advances each time the first one wraps back to zero.

Top module: `edge_step_counter`

## Requirements
- R1: With the fall-step input high, a low-to-high transition of the rise-step input increments the count by one.
- R2: With the rise-step input low, a high-to-low transition of the fall-step input increments the count by one.
- R3: The count does not change on any other activity. This covers a rise-step rising edge with fall-step low, a rise-step falling edge, a fall-step rising edge, and a fall-step falling edge with rise-step high.
- R4: While the zero input is high, the count is 0. Transitions on the step inputs are ignored during that time.
- R5: With MODULUS = 16, the count runs 0 to 15 and the step after 15 gives 0.
- R6: With MODULUS = 10, the count runs 0 to 9 and the step after 9 gives 0. A held value above 9 returns to 0 on the next step.
- R7: A rise-step rising edge and a fall-step falling edge that arrive in the same system cycle produce a single increment. The rising edge must be qualified by fall-step having been high before, and the falling edge by rise-step having been low before.
- R8: A step input change made between two system-clock edges is visible on the count output on the third following rising system-clock edge, and not before.
- R9: A step transition that becomes visible in the same system cycle as the zero input's release is ignored. The count stays 0, and later transitions count normally.
- R10: Two counters chained as described (second rise-step tied low, second fall-step driven by the first counter's most significant output bit) together count as a two-digit number.
- R11: While rst_n is low, the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all control inputs |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| adv_rise_i | input | 1 | Rise-step input; its rising edge counts while adv_fall_i is high |
| adv_fall_i | input | 1 | Fall-step input; its falling edge counts while adv_rise_i is low |
| zero_i | input | 1 | Active-high level that forces and holds the count at zero |
| count_o | output | CNT_W (4) | Present count, bit CNT_W-1 most significant |

## Verification
The step inputs are driven in four ways: a single rising edge on the rise-step input, a single falling edge on the fall-step input, each of the non-qualifying transitions, and both inputs switching together. These patterns separate correct gating from a counter that reacts to any edge, or to the wrong polarity. The zero input is raised while steps keep arriving, and is released in the same cycle as a step. This tells true priority and release masking apart from a clear that only acts once. Both variants are run through full wraps; for the decade variant this is done as a two-stage ripple chain checked against a two-digit reference through more than two wraps of the upper digit.

// File: rtl/edge_step_counter_pkg.sv
package edge_step_counter_pkg;

  // Synchronized control levels, one bit each
  typedef struct packed {
    logic rise;
    logic fall;
    logic zero;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/esc_sync.sv
module esc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i[gi]};
      end
      assign sync_o[gi] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/esc_event.sv
module esc_event (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_lvl_i,
  input  logic fall_lvl_i,
  output logic step_o
);

  logic rise_q, fall_q;
  logic rise_hit, fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_lvl_i;
      fall_q <= fall_lvl_i;
    end
  end

  // Gate each edge with the other input's level before this cycle, so
  // simultaneous qualifying motion on both inputs still yields a step.
  assign rise_hit = rise_lvl_i & ~rise_q & fall_q;
  assign fall_hit = ~fall_lvl_i & fall_q & ~rise_q;
  assign step_o   = rise_hit | fall_hit;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o); // R7

endmodule

// File: rtl/esc_core.sv
module esc_core #(
  parameter int MODULUS = 16,
  localparam int CNT_W  = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             zero_lvl_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             zero_q;
  logic             hold_zero;

  // Any value at or past the last state returns to zero
  assign cnt_nxt   = (cnt_q >= LAST) ? '0 : cnt_q + CNT_W'(1);
  assign hold_zero = zero_lvl_i | zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      zero_q <= zero_lvl_i;
      if (hold_zero)   cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_nxt;
    end
  end

  assign count_o = cnt_q;

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !hold_zero) |=> (cnt_q != $past(cnt_q))); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !hold_zero) |=> $stable(cnt_q)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_lvl_i |=> (cnt_q == '0)); // R4
  AST_RELEASE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_q && !zero_lvl_i) |=> (cnt_q == '0)); // R9
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6

endmodule

// File: rtl/edge_step_counter.sv
module edge_step_counter
  import edge_step_counter_pkg::*;
#(
  parameter int MODULUS     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_rise_i,
  input  logic             adv_fall_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] count_o
);

  ctl_t ctl_raw, ctl_syn;
  logic step;

  assign ctl_raw = '{rise: adv_rise_i, fall: adv_fall_i, zero: zero_i};

  esc_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ctl_raw),
    .sync_o  (ctl_syn)
  );

  esc_event u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_lvl_i (ctl_syn.rise),
    .fall_lvl_i (ctl_syn.fall),
    .step_o     (step)
  );

  esc_core #(.MODULUS(MODULUS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .zero_lvl_i (ctl_syn.zero),
    .count_o    (count_o)
  );

endmodule

// File: tb/edge_step_counter_test.sv
module edge_step_counter_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // Binary instance under test
  logic u_a = 1'b0, u_b = 1'b1, u_z = 1'b0;
  logic [3:0] u_q;
  // Decade ripple chain
  logic c_a = 1'b0, c_z = 1'b0;
  logic [3:0] lo_q, hi_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  edge_step_counter #(.MODULUS(16)) uut (
    .clk(clk), .rst_n(rst_n), .adv_rise_i(u_a), .adv_fall_i(u_b),
    .zero_i(u_z), .count_o(u_q));

  edge_step_counter #(.MODULUS(10)) dec_lo (
    .clk(clk), .rst_n(rst_n), .adv_rise_i(c_a), .adv_fall_i(1'b1),
    .zero_i(c_z), .count_o(lo_q));

  edge_step_counter #(.MODULUS(10)) dec_hi (
    .clk(clk), .rst_n(rst_n), .adv_rise_i(1'b0), .adv_fall_i(lo_q[3]),
    .zero_i(c_z), .count_o(hi_q));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_pulse();
    u_a = 1'b1; settle(4);
    u_a = 1'b0; settle(4);
  endtask

  task automatic t_reset();
    settle(2);
    check("R11 count during reset", u_q, 0);
    check("R11 decade count during reset", lo_q, 0);
    rst_n = 1'b1;
    settle(4);
    check("R11 count after reset", u_q, 0);
  endtask

  task automatic t_rise_latency();
    u_a = 1'b1;
    settle(2);
    check("R8 no change before third edge", u_q, 0);
    settle(1);
    check("R8 R1 increment on third edge", u_q, 1);
    u_a = 1'b0; settle(4);
    rise_pulse();
    check("R1 second rising step", u_q, 2);
  endtask

  task automatic t_fall_step();
    u_b = 1'b0; settle(5);
    check("R2 fall-step increments", u_q, 3);
    u_b = 1'b1; settle(5);
    check("R3 fall-step rising edge ignored", u_q, 3);
  endtask

  task automatic t_ignored();
    u_b = 1'b0; settle(5);
    check("R2 setup step", u_q, 4);
    u_a = 1'b1; settle(5);
    check("R3 rise with fall-step low ignored", u_q, 4);
    u_b = 1'b1; settle(5);
    check("R3 fall-step rise ignored", u_q, 4);
    u_b = 1'b0; settle(5);
    check("R3 fall-step fall with rise-step high ignored", u_q, 4);
    u_b = 1'b1; settle(5);
    u_a = 1'b0; settle(5);
    check("R3 rise-step falling edge ignored", u_q, 4);
  endtask

  task automatic t_both();
    u_a = 1'b1; u_b = 1'b0; settle(6);
    check("R7 simultaneous events give one step", u_q, 5);
    u_a = 1'b0; settle(4);
    u_b = 1'b1; settle(4);
    check("R7 restore levels no step", u_q, 5);
  endtask

  task automatic t_clear();
    u_z = 1'b1; settle(4);
    check("R4 zero forces count", u_q, 0);
    u_a = 1'b1; settle(4);
    u_a = 1'b0; settle(4);
    check("R4 steps ignored while zero held", u_q, 0);
    u_z = 1'b0; settle(4);
  endtask

  task automatic t_release();
    u_z = 1'b1; settle(4);
    u_z = 1'b0; u_a = 1'b1; settle(6);
    check("R9 step at release ignored", u_q, 0);
    u_a = 1'b0; settle(4);
    rise_pulse();
    check("R9 later step counts", u_q, 1);
  endtask

  task automatic t_wrap_bin();
    int exp = 1;
    for (int i = 0; i < 16; i++) begin
      rise_pulse();
      exp = (exp + 1) % 16;
      check("R5 binary sequence", u_q, exp);
    end
  endtask

  task automatic t_cascade();
    int ref_cnt = 0;
    c_z = 1'b1; settle(4);
    check("R4 chain cleared lo", lo_q, 0);
    check("R4 chain cleared hi", hi_q, 0);
    c_z = 1'b0; settle(4);
    for (int i = 0; i < 230; i++) begin
      c_a = 1'b1; settle(4);
      c_a = 1'b0; settle(4);
      ref_cnt = (ref_cnt + 1) % 100;
      check("R6 decade low digit", lo_q, ref_cnt % 10);
      check("R10 ripple high digit", hi_q, ref_cnt / 10);
    end
  endtask

  initial begin
    t_reset();
    t_rise_latency();
    t_fall_step();
    t_ignored();
    t_both();
    t_clear();
    t_release();
    t_wrap_bin();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R-all watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule